// File: doc/BRIEF.md
# Toggle-Based Strobe Crossing with Source Busy

This block moves a one-cycle strobe from one clock domain into another clock domain that has no fixed relation to the first. On the destination side the strobe appears as a pulse exactly one destination cycle wide. On the source side a strobe flips a level. That level travels to the destination through a chain of destination-clocked flops. The destination compares it against the level it held one cycle earlier and emits a pulse whenever the two differ.

The destination's synchronized level also travels back to the source domain. While the returned level still differs from the source level, a busy flag is high. Any strobe that arrives while busy is high is refused: it changes nothing and never reaches the destination. The block works whether the source clock is much faster than the destination clock or much slower, because every event is carried as a held level and not as a narrow pulse.

Top module: `pulse_crossing`

## Requirements
- R1: A source strobe that is sampled while busy is low flips the internal source level at that source clock edge, and so schedules exactly one destination pulse.
- R2: `pulseOut` is never high for two destination cycles in a row.
- R3: The number of destination pulses equals the number of accepted source strobes, and each pulse follows its own strobe before the next strobe is accepted.
- R4: With the source clock 40 times faster than the destination clock, a strobe that lasts one source cycle is never lost.
- R5: A strobe sampled while `busyOut` is high has no effect: it produces no destination pulse and does not extend busy.
- R6: `busyOut` is high in the source cycle that follows an accepted strobe. It returns low once the level that comes back from the destination matches the source level.
- R7: The block works unchanged when the destination clock is faster than the source clock.
- R8: During reset and after it, `busyOut` and `pulseOut` are low, and no destination pulse appears until a strobe is accepted.
- R9: The destination pulse is seen no later than SYNC_STAGES+2 destination edges after the strobe is accepted (default 2 stages).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain asynchronous reset, active low |
| pulseIn | input | 1 | One-cycle strobe in the source domain |
| busyOut | output | 1 | High while a transfer is in flight; strobes are refused |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain asynchronous reset, active low |
| pulseOut | output | 1 | One-cycle pulse in the destination domain |

## Verification
On every cycle the assertions check four things: the output pulse width, that the source level flips only on an accepted strobe, that busy rises right after an acceptance, and that a refused strobe leaves the level alone. Other properties span both clocks and only the bench's scenarios can show them. These are the count and order of delivered pulses, the latency bound, behaviour at a 40:1 clock ratio in each direction, and the absence of any pulse after reset.

// File: rtl/pulse_crossing_pkg.sv
`timescale 1ns/1ps
package pulse_crossing_pkg;
  // Control to datapath strobes in the source domain
  typedef struct packed {
    logic flip;   // accept the current strobe: invert the source level
    logic busy;   // a transfer is in flight
  } srcStrobe_t;
endpackage

// File: rtl/pc_sync.sv
`timescale 1ns/1ps
module pc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/pc_src_ctrl.sv
`timescale 1ns/1ps
module pc_src_ctrl
  import pulse_crossing_pkg::*;
#(
  parameter int ACK_STAGES = 2
) (
  input  logic       srcClk,
  input  logic       srcRstN,
  input  logic       pulseIn,
  input  logic       toggleLevel,
  input  logic       returnLevel,   // destination level, asynchronous here
  output srcStrobe_t strobe
);
  logic ackLevel;

  pc_sync #(.STAGES(ACK_STAGES)) u_ackSync (
    .clk (srcClk),
    .rstN(srcRstN),
    .d   (returnLevel),
    .q   (ackLevel)
  );

  always_comb begin
    strobe.busy = toggleLevel ^ ackLevel;
    strobe.flip = pulseIn & ~strobe.busy;
  end
endmodule

// File: rtl/pc_src_datapath.sv
`timescale 1ns/1ps
module pc_src_datapath
  import pulse_crossing_pkg::*;
(
  input  logic       srcClk,
  input  logic       srcRstN,
  input  srcStrobe_t strobe,
  output logic       toggleLevel
);
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)         toggleLevel <= 1'b0;
    else if (strobe.flip) toggleLevel <= ~toggleLevel;
  end
endmodule

// File: rtl/pc_dst_datapath.sv
`timescale 1ns/1ps
module pc_dst_datapath #(
  parameter int SYNC_STAGES = 2
) (
  input  logic dstClk,
  input  logic dstRstN,
  input  logic toggleLevel,   // source level, asynchronous here
  output logic syncLevel,
  output logic pulseOut
);
  logic prevLevel;

  pc_sync #(.STAGES(SYNC_STAGES)) u_fwdSync (
    .clk (dstClk),
    .rstN(dstRstN),
    .d   (toggleLevel),
    .q   (syncLevel)
  );

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) prevLevel <= 1'b0;
    else          prevLevel <= syncLevel;
  end

  assign pulseOut = syncLevel ^ prevLevel;
endmodule

// File: rtl/pulse_crossing.sv
`timescale 1ns/1ps
module pulse_crossing
  import pulse_crossing_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_STAGES  = 2
) (
  input  logic srcClk,
  input  logic srcRstN,
  input  logic pulseIn,
  output logic busyOut,
  input  logic dstClk,
  input  logic dstRstN,
  output logic pulseOut
);
  srcStrobe_t srcStrobe;
  logic       toggleLevel;
  logic       syncLevel;

  pc_src_ctrl #(.ACK_STAGES(ACK_STAGES)) u_srcCtrl (
    .srcClk     (srcClk),
    .srcRstN    (srcRstN),
    .pulseIn    (pulseIn),
    .toggleLevel(toggleLevel),
    .returnLevel(syncLevel),
    .strobe     (srcStrobe)
  );

  pc_src_datapath u_srcData (
    .srcClk     (srcClk),
    .srcRstN    (srcRstN),
    .strobe     (srcStrobe),
    .toggleLevel(toggleLevel)
  );

  pc_dst_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dstData (
    .dstClk     (dstClk),
    .dstRstN    (dstRstN),
    .toggleLevel(toggleLevel),
    .syncLevel  (syncLevel),
    .pulseOut   (pulseOut)
  );

  assign busyOut = srcStrobe.busy;
endmodule

// File: rtl/pulse_crossing_checker.sv
`timescale 1ns/1ps
module pulse_crossing_checker (
  input logic srcClk,
  input logic srcRstN,
  input logic pulseIn,
  input logic busyOut,
  input logic dstClk,
  input logic dstRstN,
  input logic pulseOut,
  input logic toggleLevel
);
  AST_PULSE_SINGLE_CYCLE: assert property (@(posedge dstClk) disable iff (!dstRstN)
    pulseOut |=> !pulseOut); // R2

  AST_FLIP_ONLY_ON_ACCEPT: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (toggleLevel != $past(toggleLevel)) |-> ($past(pulseIn) && !$past(busyOut))); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (pulseIn && !busyOut) |=> busyOut); // R6

  AST_REFUSED_NO_EFFECT: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (pulseIn && busyOut) |=> $stable(toggleLevel)); // R5
endmodule

bind pulse_crossing pulse_crossing_checker u_checker (
  .srcClk     (srcClk),
  .srcRstN    (srcRstN),
  .pulseIn    (pulseIn),
  .busyOut    (busyOut),
  .dstClk     (dstClk),
  .dstRstN    (dstRstN),
  .pulseOut   (pulseOut),
  .toggleLevel(toggleLevel)
);

// File: tb/pulse_crossing_bench.sv
`timescale 1ns/1ps
module pulse_crossing_bench;
  localparam int SYNC = 2;

  logic srcClk = 0, dstClk = 0, srcRstN = 0, dstRstN = 0, pulseIn = 0;
  logic busyOut, pulseOut;
  realtime dstHalf = 200.0;

  int testsRun = 0, testsFailed = 0;
  int dstPulses = 0, wideCount = 0;
  bit prevHigh = 0;

  pulse_crossing #(.SYNC_STAGES(SYNC), .ACK_STAGES(2)) u_pulse_crossing (
    .srcClk(srcClk), .srcRstN(srcRstN), .pulseIn(pulseIn), .busyOut(busyOut),
    .dstClk(dstClk), .dstRstN(dstRstN), .pulseOut(pulseOut)
  );

  always #5 srcClk = ~srcClk;
  always #(dstHalf) dstClk = ~dstClk;

  // Pulse monitor, sampled mid destination cycle
  always @(negedge dstClk) begin
    if (pulseOut) begin
      dstPulses++;
      if (prevHigh) wideCount++;
    end
    prevHigh = pulseOut;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendPulse(output bit accepted);
    @(negedge srcClk);
    accepted = !busyOut;
    pulseIn = 1;
    @(negedge srcClk);
    pulseIn = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busyOut && n < 20000) begin
      @(negedge srcClk);
      n++;
    end
    repeat (2) @(negedge dstClk);
    #0.1;
  endtask

  task automatic testReset();
    #3;
    check(!busyOut && !pulseOut, "R8", "outputs in reset", {busyOut, pulseOut}, 0);
    repeat (3) @(negedge srcClk);
    srcRstN = 1;
    dstRstN = 1;
    repeat (10) @(negedge dstClk);
    #0.1;
    check(dstPulses == 0, "R8", "pulses after reset", dstPulses, 0);
    check(!busyOut, "R8", "busy after reset", busyOut, 0);
  endtask

  task automatic testFastToSlow();
    int start = dstPulses;
    dstHalf = 200.0;
    repeat (2) @(negedge dstClk);
    for (int i = 0; i < 4; i++) begin
      bit acc;
      int base, n;
      repeat ($urandom_range(1, 30)) @(negedge srcClk);
      base = dstPulses;
      sendPulse(acc);
      check(acc, "R4", "strobe accepted when idle", acc, 1);
      check(busyOut, "R6", "busy after accept", busyOut, 1);
      n = 0;
      while (dstPulses == base && n < 10) begin
        @(negedge dstClk);
        #0.1;
        n++;
      end
      check(n <= SYNC + 2, "R9", "latency in dst edges", n, SYNC + 2);
      waitIdle();
      check(!busyOut, "R6", "busy returns low", busyOut, 0);
      check(dstPulses == base + 1, "R3", "one pulse per strobe", dstPulses - base, 1);
    end
    check(dstPulses - start == 4, "R4", "fast-to-slow total", dstPulses - start, 4);
    check(wideCount == 0, "R2", "wide pulses", wideCount, 0);
  endtask

  task automatic testRefuse();
    bit acc;
    int base = dstPulses;
    int refused = 0;
    dstHalf = 200.0;
    sendPulse(acc);
    check(acc, "R1", "first strobe accepted", acc, 1);
    for (int i = 0; i < 3; i++) begin
      sendPulse(acc);
      if (!acc) refused++;
    end
    check(refused == 3, "R5", "strobes refused while busy", refused, 3);
    waitIdle();
    check(dstPulses - base == 1, "R5", "refused strobes give no pulse", dstPulses - base, 1);
  endtask

  task automatic testSlowToFast();
    int base;
    int accCount = 0;
    dstHalf = 0.125;
    repeat (4) @(negedge dstClk);
    base = dstPulses;
    for (int i = 0; i < 6; i++) begin
      bit acc;
      repeat ($urandom_range(1, 8)) @(negedge srcClk);
      sendPulse(acc);
      if (acc) accCount++;
      waitIdle();
    end
    check(accCount == 6, "R7", "all strobes accepted", accCount, 6);
    check(dstPulses - base == 6, "R7", "slow-to-fast pulses", dstPulses - base, 6);
    check(wideCount == 0, "R2", "wide pulses fast dst", wideCount, 0);
  endtask

  task automatic testBurst();
    int base;
    int accCount = 0;
    dstHalf = 7.0;
    repeat (4) @(negedge dstClk);
    base = dstPulses;
    for (int i = 0; i < 60; i++) begin
      @(negedge srcClk);
      if (!busyOut) accCount++;
      pulseIn = 1;
    end
    @(negedge srcClk);
    pulseIn = 0;
    waitIdle();
    check(accCount >= 2 && accCount < 60, "R5", "burst partly refused", accCount, 2);
    check(dstPulses - base == accCount, "R3", "burst pulses match accepts",
          dstPulses - base, accCount);
    check(wideCount == 0, "R2", "wide pulses burst", wideCount, 0);
  endtask

  initial begin
    #1_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testFastToSlow();
    testRefuse();
    testSlowToFast();
    testBurst();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule